// File: doc/BRIEF.md
# Host-to-Device Transfer Control Channel

This block is the device-side sequencer for one inbound channel, where the host pushes data to the device. The host programs it through a small write port. It writes a packed offset/last word and a transfer length in 32-bit words. It then writes a 64-bit scatter-gather list address as two 32-bit halves, followed by the list length in words. Writing the list length starts a request on a simplified list-fetch interface. The request is held until the fetcher acknowledges it.

Once the list has been taken, the channel raises a one-cycle list-consumed pulse. It then counts data words reported by a data-mover stub. While the transaction is still running, the host may write a fresh address and list length after each consumed pulse, so a long transfer is fed in refillable pieces. The transaction ends in one of two ways: the received word count reaches the programmed length, or the data mover signals an early end. At that point a one-cycle done pulse is raised and the count stays readable on `xfer_words`. A zero length is recorded without any fetch.

The sequencer has six states:
- IDLE accepts offset/last and length writes.
- A non-zero length moves IDLE to ARMED.
- A list-length write moves ARMED to FETCH.
- The fetch acknowledge moves FETCH to NOTIFY, which lasts one cycle and then moves to STREAM.
- A new list-length write moves NOTIFY or STREAM back to FETCH (refill).
- Completion moves FETCH, NOTIFY or STREAM to DONE, which lasts one cycle and then returns to IDLE.

Top module: `h2d_chan_ctrl`

## Requirements
- R1: After reset, `fetch_req`, `list_done`, `txn_done`, `chain_open` and `txn_last` are 0, and `xfer_words` is 0.
- R2: A write to select 0 (offset/last) in IDLE sets `txn_offset` to data bits [31:1] and `txn_last` to data bit 0, visible the cycle after the write.
- R3: A non-zero write to select 1 (length, in 32-bit words) in IDLE clears `xfer_words` to 0 and arms the channel. No fetch starts until the list length is written.
- R4: A zero length write in IDLE clears `xfer_words` and sets `chain_open` to the inverse of the stored last flag. It starts no fetch and raises no done pulse. A list-length write that follows in IDLE also starts no fetch.
- R5: Selects 2 and 3 write the low and high halves of the list address. A non-zero write to select 4 (list length in words, four words per element) while armed or streaming raises `fetch_req` the next cycle. At that point `fetch_addr` = {high, low} and `fetch_elems` = data[31:2]. The request holds until `fetch_ack`.
- R6: The cycle after `fetch_req` and `fetch_ack` are both high, `list_done` is high for exactly one cycle and `fetch_req` is low.
- R7: After a list-consumed pulse, a new address and list-length write in the same transaction starts a new fetch with the new values. The word count carries on.
- R8: `dm_words` is added to `xfer_words` when `dm_valid` is high during FETCH, NOTIFY or STREAM. It is ignored in IDLE.
- R9: When the count including this cycle's words reaches or exceeds the length, `txn_done` pulses once on the next cycle. `xfer_words` then holds the true total, including any overshoot.
- R10: `dm_early_end` completes the transaction with the count so far, plus any words valid in the same cycle.
- R11: All register writes are ignored while `fetch_req` is outstanding.
- R12: On completion, `chain_open` becomes 1 if the last flag was 0 and 0 if it was 1.
- R13: Offset/last and length writes outside IDLE are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 offset/last, 1 length, 2 list addr low, 3 list addr high, 4 list length |
| wr_data | input | 32 | Write data |
| txn_offset | output | 31 | Stored transaction offset |
| txn_last | output | 1 | Stored last flag |
| chain_open | output | 1 | Further transactions expected |
| fetch_req | output | 1 | List fetch request |
| fetch_addr | output | 64 | List address |
| fetch_elems | output | 30 | List element count |
| fetch_ack | input | 1 | Fetcher took the list |
| list_done | output | 1 | List-consumed pulse |
| dm_valid | input | 1 | Data mover word report valid |
| dm_words | input | 8 | Words moved this cycle |
| dm_early_end | input | 1 | Data mover ends the transaction |
| txn_done | output | 1 | Transaction-done pulse |
| xfer_words | output | 32 | Words transferred |

## Verification
The main function is driven with four transaction shapes:
- A single list with an exact-length finish. This separates length-reached completion from any other completion path.
- A two-piece refill that ends early with words in the same cycle. This shows the count survives a refill and that early-end words are included.
- A zero-length transaction. This shows no fetch is raised even when a list length follows.
- An overshooting data report. This shows the latched count is the true total and is not clipped to the length.

Writes injected while a fetch is outstanding, and offset/length writes made during streaming, are checked through an unchanged fetch address, the absence of a second fetch, and completion at the original length.

// File: rtl/h2d_pkg.sv
package h2d_pkg;
    typedef enum logic [2:0] {
        SEL_OFFLAST  = 3'd0,
        SEL_LEN      = 3'd1,
        SEL_LIST_LO  = 3'd2,
        SEL_LIST_HI  = 3'd3,
        SEL_LIST_LEN = 3'd4
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_FETCH,
        ST_NOTIFY,
        ST_STREAM,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/h2d_regs.sv
module h2d_regs
    import h2d_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           wr_sel,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 meta_we,
    input  logic                 list_we,
    input  logic                 sg_we,
    output logic [REG_W-1:0]     offlast_q,
    output logic [REG_W-1:0]     len_q,
    output logic [2*REG_W-1:0]   addr_q,
    output logic [REG_W-1:0]     sg_words_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offlast_q <= '0;
            len_q     <= '0;
        end else if (meta_we) begin
            if (wr_sel == SEL_OFFLAST) offlast_q <= wr_data;
            if (wr_sel == SEL_LEN)     len_q     <= wr_data;
        end
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam logic [2:0] HALF_SEL = 3'(int'(SEL_LIST_LO) + h);
        logic [REG_W-1:0] half_r;
        always_ff @(posedge clk) begin
            if (!rst_n)
                half_r <= '0;
            else if (list_we && wr_sel == HALF_SEL)
                half_r <= wr_data;
        end
        assign addr_q[h*REG_W +: REG_W] = half_r;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sg_words_q <= '0;
        else if (sg_we)
            sg_words_q <= wr_data;
    end
endmodule

// File: rtl/h2d_count.sv
module h2d_count #(
    parameter int REG_W = 32,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             dm_valid,
    input  logic [CNT_W-1:0] dm_words,
    output logic [REG_W-1:0] words_q,
    output logic [REG_W-1:0] words_nx
);
    localparam int PAD = REG_W - CNT_W;

    always_comb begin
        words_nx = words_q;
        if (en && dm_valid)
            words_nx = words_q + {{PAD{1'b0}}, dm_words};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            words_q <= '0;
        else if (clr)
            words_q <= '0;
        else if (en)
            words_q <= words_nx;
    end
endmodule

// File: rtl/h2d_seq.sv
module h2d_seq
    import h2d_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] len_q,
    input  logic             last_q,
    input  logic [REG_W-1:0] words_nx,
    input  logic             dm_valid,
    input  logic             dm_early_end,
    input  logic             fetch_ack,
    output logic             meta_we,
    output logic             list_we,
    output logic             sg_we,
    output logic             cnt_clr,
    output logic             cnt_en,
    output logic             fetch_req,
    output logic             list_done,
    output logic             txn_done,
    output logic             chain_open
);
    seq_state_e state, nxt;

    logic in_idle, can_list, can_refill, complete, len_wr, len_zero;

    assign in_idle    = (state == ST_IDLE);
    assign can_refill = (state == ST_ARMED) || (state == ST_NOTIFY) || (state == ST_STREAM);
    assign can_list   = in_idle || can_refill;
    assign cnt_en     = (state == ST_FETCH) || (state == ST_NOTIFY) || (state == ST_STREAM);
    assign complete   = cnt_en && ((dm_valid && (words_nx >= len_q)) || dm_early_end);

    assign meta_we  = wr_en && in_idle && (wr_sel == SEL_OFFLAST || wr_sel == SEL_LEN);
    assign len_wr   = wr_en && in_idle && (wr_sel == SEL_LEN);
    assign len_zero = (wr_data == '0);
    assign list_we  = wr_en && can_list && (wr_sel == SEL_LIST_LO || wr_sel == SEL_LIST_HI);
    assign sg_we    = wr_en && can_refill && (wr_sel == SEL_LIST_LEN)
                      && (wr_data[REG_W-1:2] != '0);
    assign cnt_clr  = len_wr;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (len_wr && !len_zero) nxt = ST_ARMED;
            ST_ARMED:  if (sg_we) nxt = ST_FETCH;
            ST_FETCH: begin
                if (complete)       nxt = ST_DONE;
                else if (fetch_ack) nxt = ST_NOTIFY;
            end
            ST_NOTIFY, ST_STREAM: begin
                if (complete)   nxt = ST_DONE;
                else if (sg_we) nxt = ST_FETCH;
                else            nxt = ST_STREAM;
            end
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        fetch_req = (state == ST_FETCH);
        list_done = (state == ST_NOTIFY);
        txn_done  = (state == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_open <= 1'b0;
        else if (complete || (len_wr && len_zero))
            chain_open <= !last_q;
    end
endmodule

// File: rtl/h2d_chan_ctrl.sv
module h2d_chan_ctrl
    import h2d_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-2:0]   txn_offset,
    output logic               txn_last,
    output logic               chain_open,
    output logic               fetch_req,
    output logic [2*REG_W-1:0] fetch_addr,
    output logic [REG_W-3:0]   fetch_elems,
    input  logic               fetch_ack,
    output logic               list_done,
    input  logic               dm_valid,
    input  logic [CNT_W-1:0]   dm_words,
    input  logic               dm_early_end,
    output logic               txn_done,
    output logic [REG_W-1:0]   xfer_words
);
    localparam int ADDR_W = 2 * REG_W;

    logic               meta_we, list_we, sg_we, cnt_clr, cnt_en;
    logic [REG_W-1:0]   offlast_q, len_q, sg_words_q, words_nx;
    logic [ADDR_W-1:0]  addr_q;

    h2d_regs #(.REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_data(wr_data),
        .meta_we(meta_we), .list_we(list_we), .sg_we(sg_we),
        .offlast_q(offlast_q), .len_q(len_q), .addr_q(addr_q),
        .sg_words_q(sg_words_q)
    );

    h2d_count #(.REG_W(REG_W), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
        .dm_valid(dm_valid), .dm_words(dm_words),
        .words_q(xfer_words), .words_nx(words_nx)
    );

    h2d_seq #(.REG_W(REG_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .len_q(len_q), .last_q(offlast_q[0]),
        .words_nx(words_nx), .dm_valid(dm_valid), .dm_early_end(dm_early_end),
        .fetch_ack(fetch_ack), .meta_we(meta_we), .list_we(list_we),
        .sg_we(sg_we), .cnt_clr(cnt_clr), .cnt_en(cnt_en),
        .fetch_req(fetch_req), .list_done(list_done), .txn_done(txn_done),
        .chain_open(chain_open)
    );

    assign txn_offset  = offlast_q[REG_W-1:1];
    assign txn_last    = offlast_q[0];
    assign fetch_addr  = addr_q;
    assign fetch_elems = sg_words_q[REG_W-1:2];
endmodule

// File: rtl/h2d_chan_ctrl_chk.sv
module h2d_chan_ctrl_chk #(
    parameter int REG_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fetch_req,
    input logic               fetch_ack,
    input logic [2*REG_W-1:0] fetch_addr,
    input logic               list_done,
    input logic               txn_done,
    input logic               dm_valid,
    input logic               dm_early_end,
    input logic [REG_W-1:0]   xfer_words
);
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_ack && !dm_valid && !dm_early_end |=> fetch_req);

    // R11
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_ack |=> $stable(fetch_addr));

    // R6
    list_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        list_done |-> $past(fetch_req && fetch_ack));

    // R6
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_req, list_done, txn_done}));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |=> !txn_done);

    // R9
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |=> $stable(xfer_words));
endmodule

bind h2d_chan_ctrl h2d_chan_ctrl_chk #(.REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
    .fetch_addr(fetch_addr), .list_done(list_done), .txn_done(txn_done),
    .dm_valid(dm_valid), .dm_early_end(dm_early_end), .xfer_words(xfer_words)
);

// File: tb/sim_h2d_chan_ctrl.sv
`timescale 1ns/1ps
module sim_h2d_chan_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [30:0] txn_offset;
    logic        txn_last, chain_open, fetch_req, list_done, txn_done;
    logic [63:0] fetch_addr;
    logic [29:0] fetch_elems;
    logic        fetch_ack = 1'b0;
    logic        dm_valid = 1'b0;
    logic [7:0]  dm_words = '0;
    logic        dm_early_end = 1'b0;
    logic [31:0] xfer_words;

    always #2.5 clk = ~clk;

    h2d_chan_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .txn_offset(txn_offset), .txn_last(txn_last), .chain_open(chain_open),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_elems(fetch_elems),
        .fetch_ack(fetch_ack), .list_done(list_done), .dm_valid(dm_valid),
        .dm_words(dm_words), .dm_early_end(dm_early_end), .txn_done(txn_done),
        .xfer_words(xfer_words)
    );

    typedef struct {
        int          kind;   // 1 fetch, 2 list consumed, 3 done
        logic [63:0] a;
        logic [31:0] b;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    logic req_d = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input logic [63:0] a, input logic [31:0] b,
                             input string req);
        exp_t e;
        e.kind = kind; e.a = a; e.b = b; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic pop_cmp(input int kind, input logic [63:0] a, input logic [31:0] b);
        exp_t e;
        if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL unexpected event actual=%0d expected=none", kind);
        end else begin
            e = exp_q.pop_front();
            chk({e.req, " kind"}, 64'(kind), 64'(e.kind));
            chk({e.req, " a"}, a, e.a);
            chk({e.req, " b"}, 64'(b), 64'(e.b));
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (fetch_req && !req_d) pop_cmp(1, fetch_addr, 32'(fetch_elems));
            if (list_done) begin
                pop_cmp(2, 64'd0, 32'd0);
                chk("R6 req low at list pulse", 64'(fetch_req), 64'd0);
            end
            if (txn_done) pop_cmp(3, 64'(chain_open), xfer_words);
        end
        req_d <= fetch_req;
    end

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); fetch_ack = 1'b1;
        @(negedge clk); fetch_ack = 1'b0;
    endtask

    task automatic data(input logic [7:0] n, input logic early);
        @(negedge clk); dm_valid = (n != 0); dm_words = n; dm_early_end = early;
        @(negedge clk); dm_valid = 1'b0; dm_words = '0; dm_early_end = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 fetch_req", 64'(fetch_req), 0);
        chk("R1 list_done", 64'(list_done), 0);
        chk("R1 txn_done", 64'(txn_done), 0);
        chk("R1 chain_open", 64'(chain_open), 0);
        chk("R1 txn_last", 64'(txn_last), 0);
        chk("R1 xfer_words", 64'(xfer_words), 0);

        // Transaction A: single list, exact length
        wr(3'd0, 32'h0000_000B);
        chk("R2 offset", 64'(txn_offset), 5);
        chk("R2 last", 64'(txn_last), 1);
        wr(3'd1, 32'd10);
        chk("R3 words cleared", 64'(xfer_words), 0);
        wr(3'd2, 32'h9ABC_DEF0);
        wr(3'd3, 32'h1234_5678);
        chk("R3 no fetch before list len", 64'(fetch_req), 0);
        expect_ev(1, 64'h1234_5678_9ABC_DEF0, 32'd2, "R5 fetch A");
        wr(3'd4, 32'd8);
        wr(3'd2, 32'hDEAD_0000);
        wr(3'd4, 32'd16);
        wr(3'd1, 32'd99);
        chk("R11 addr unchanged", fetch_addr, 64'h1234_5678_9ABC_DEF0);
        chk("R5 req held", 64'(fetch_req), 1);
        expect_ev(2, 0, 0, "R6 list A");
        ack();
        data(8'd4, 1'b0);
        chk("R8 count 4", 64'(xfer_words), 4);
        expect_ev(3, 64'd0, 32'd10, "R9 done A");
        data(8'd6, 1'b0);
        chk("R12 chain closed", 64'(chain_open), 0);

        // Transaction B: refill, early end
        wr(3'd0, 32'd14);
        chk("R2 last 0", 64'(txn_last), 0);
        wr(3'd1, 32'd20);
        wr(3'd2, 32'h0000_1000);
        wr(3'd3, 32'h0);
        expect_ev(1, 64'h1000, 32'd1, "R5 fetch B1");
        wr(3'd4, 32'd4);
        expect_ev(2, 0, 0, "R6 list B1");
        ack();
        data(8'd5, 1'b0);
        wr(3'd2, 32'h0000_2000);
        wr(3'd3, 32'h1);
        wr(3'd1, 32'd3);
        wr(3'd0, 32'd1);
        chk("R13 last unchanged", 64'(txn_last), 0);
        chk("R13 words kept", 64'(xfer_words), 5);
        expect_ev(1, 64'h1_0000_2000, 32'd3, "R7 refill fetch");
        wr(3'd4, 32'd12);
        expect_ev(2, 0, 0, "R7 list B2");
        ack();
        data(8'd7, 1'b0);
        chk("R7 count continues", 64'(xfer_words), 12);
        expect_ev(3, 64'd1, 32'd14, "R10 early end");
        data(8'd2, 1'b1);
        chk("R12 chain open", 64'(chain_open), 1);

        // Zero-length transaction
        wr(3'd0, 32'd1);
        wr(3'd1, 32'd0);
        chk("R4 words zero", 64'(xfer_words), 0);
        chk("R4 chain closed", 64'(chain_open), 0);
        wr(3'd4, 32'd8);
        @(negedge clk);
        chk("R4 no fetch", 64'(fetch_req), 0);
        data(8'd9, 1'b0);
        chk("R8 idle ignored", 64'(xfer_words), 0);

        // Overshoot
        wr(3'd1, 32'd5);
        wr(3'd2, 32'h40);
        wr(3'd3, 32'h0);
        expect_ev(1, 64'h40, 32'd1, "R5 fetch D");
        wr(3'd4, 32'd4);
        expect_ev(2, 0, 0, "R6 list D");
        ack();
        expect_ev(3, 64'd0, 32'd8, "R9 overshoot");
        data(8'd8, 1'b0);
        repeat (3) @(negedge clk);
        chk("R9 all events seen", 64'(exp_q.size()), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule